// File: doc/BRIEF.md
# Self-Programming Command Arming Controller

This block sits between a small CPU and its flash controller and guards the self-programming commands. Software writes a 5-bit command code into the low bits of a control register. An accepted code opens a short window. A store-program strobe that arrives inside the window launches the chosen operation, which is one of: buffer fill, page erase, page write, lock-bit set, or a read-while-write re-enable pulse. When the lock-set command is armed, a load-program strobe early in the window asks for lock or fuse bits instead.

Every operation reaches the flash controller as one registered start pulse. The pulse carries an operation code, an address derived from the Z pointer and data derived from R1:R0. Buffer fill, lock set and re-enable finish in that one cycle. Erase and write keep the block busy until the controller answers with a done pulse. During that time the command stays visible in the register. The CPU is halted when the erase or write targets the no-read-while-write region. The interfaces are plain control pins with no back-pressure. The controller must take each start pulse in the cycle it appears, and software polls the busy bit.

Top module: `selfprog_arm`

## Requirements
- R1: An accepted write arms the command for exactly WIN (4) clock edges after the write edge. A store strobe sampled on any of those edges is honoured. If no strobe comes, the command bits read as zero after the WIN-th edge.
- R2: Only the codes 00001, 00011, 00101, 01001 and 10001 are accepted. Any other write leaves the register unchanged. Any write while busy leaves it unchanged. Register read: bits [4:0] hold the armed code, bit 5 is busy, bits [7:6] are zero.
- R3: Buffer fill (00001) pulses flash_start with flash_op=1, the address equal to Z with bit 0 cleared, and the data equal to R1:R0. The command bits then read zero.
- R4: Page erase (00011, flash_op=2) and page write (00101, flash_op=3) send Z with its low PAGE_LSB bits cleared and zero data. Busy and the command bits stay set until flash_done, and then all of them clear.
- R5: halt_cpu is high from the launch of an erase or write whose Z is at or above NRWW_BASE until flash_done. It stays low for targets below NRWW_BASE.
- R6: Lock set (01001) pulses flash_op=4 with address 0 and data R0 zero-extended. The command bits then read zero.
- R7: While lock set is armed, a load strobe on one of the first three edges of the window gives a one-cycle lf_rd pulse, with lf_fuse equal to Z bit 0. The command stays armed. A load strobe later in the window gives no pulse.
- R8: The re-enable code (10001) gives a single flash_start pulse with flash_op=5 and then clears.
- R9: A register write on the same edge as a launch or a window expiry is ignored. An accepted write while armed (and not expiring) replaces the code and restarts the full window.
- R10: flash_start is high for exactly one cycle per launch. A store strobe with nothing armed, or while busy, causes no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 5 | Command code written |
| csr_rdata | output | 8 | Register read value (code, busy) |
| store_stb | input | 1 | Store-program instruction strobe |
| load_stb | input | 1 | Load-program instruction strobe |
| z_addr | input | ADDR_W | Z pointer |
| r_data | input | DATA_W | R1:R0 data word |
| flash_start | output | 1 | One-cycle operation start |
| flash_op | output | 3 | Operation code |
| flash_addr | output | ADDR_W | Operation address |
| flash_wdata | output | DATA_W | Operation data |
| flash_done | input | 1 | Erase/write completion pulse |
| flash_busy | output | 1 | Erase or write in progress |
| halt_cpu | output | 1 | CPU stall request |
| lf_rd | output | 1 | Lock/fuse read pulse |
| lf_fuse | output | 1 | 1 selects fuse bits, 0 lock bits |

## Verification
The assertions check the following on every cycle:
- an armed code never outlives its window without a new write;
- the register never holds an unaccepted code;
- busy always carries the enable bit and an erase or write bit;
- halt only occurs while busy;
- start pulses last one cycle;
- busy rises only after a store strobe.

Only the bench scenarios can show the following:
- the operation code, the address masking and the data selection for each command;
- the exact edge on which the window closes;
- the three-edge limit on the load strobe;
- which of two same-cycle events wins.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FILL  = 3'd1,
    OP_ERASE = 3'd2,
    OP_WRITE = 3'd3,
    OP_LOCK  = 3'd4,
    OP_RWW   = 3'd5
  } sp_op_e;

  localparam logic [4:0] CODE_FILL  = 5'b00001;
  localparam logic [4:0] CODE_ERASE = 5'b00011;
  localparam logic [4:0] CODE_WRITE = 5'b00101;
  localparam logic [4:0] CODE_LOCK  = 5'b01001;
  localparam logic [4:0] CODE_RWW   = 5'b10001;
endpackage

// File: rtl/selfprog_decode.sv
module selfprog_decode
  import selfprog_pkg::*;
(
  input  logic [4:0] code,
  output logic       valid,
  output sp_op_e     op
);
  always_comb begin
    valid = 1'b1;
    unique case (code)
      CODE_FILL:  op = OP_FILL;
      CODE_ERASE: op = OP_ERASE;
      CODE_WRITE: op = OP_WRITE;
      CODE_LOCK:  op = OP_LOCK;
      CODE_RWW:   op = OP_RWW;
      default: begin
        op    = OP_NONE;
        valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/selfprog_window.sv
module selfprog_window #(
  parameter int WIN     = 4,
  parameter int LPM_WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic armed,
  output logic last,
  output logic early
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_V   = CW'(WIN);
  localparam logic [CW-1:0] EARLY_V = CW'(WIN - LPM_WIN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clear)        cnt <= '0;
    else if (load)         cnt <= WIN_V;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign armed = (cnt != '0);
  assign last  = (cnt == CW'(1));
  assign early = (cnt > EARLY_V);
endmodule

// File: rtl/selfprog_launch.sv
module selfprog_launch
  import selfprog_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int PAGE_LSB = 6,
  parameter logic [ADDR_W-1:0] NRWW_BASE = 16'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  sp_op_e            op,
  input  logic              lpm_hit,
  input  logic [ADDR_W-1:0] z_addr,
  input  logic [DATA_W-1:0] r_data,
  input  logic              flash_done,
  output logic              flash_start,
  output logic [2:0]        flash_op,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_wdata,
  output logic              busy,
  output logic              halt_cpu,
  output logic              lf_rd,
  output logic              lf_fuse
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_LSB) - 1);
  localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(1);
  localparam logic [DATA_W-1:0] LOW_MASK  = DATA_W'(8'hFF);

  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;
  logic              long_op;
  logic              in_nrww;

  always_comb begin
    addr_n = '0;
    data_n = '0;
    case (op)
      OP_FILL: begin
        addr_n = z_addr & ~WORD_MASK;
        data_n = r_data;
      end
      OP_ERASE, OP_WRITE: addr_n = z_addr & ~PAGE_MASK;
      OP_LOCK:  data_n = r_data & LOW_MASK;
      default: ;
    endcase
  end

  assign long_op = (op == OP_ERASE) || (op == OP_WRITE);
  assign in_nrww = (z_addr >= NRWW_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_start <= 1'b0;
      flash_op    <= 3'd0;
      flash_addr  <= '0;
      flash_wdata <= '0;
      busy        <= 1'b0;
      halt_cpu    <= 1'b0;
      lf_rd       <= 1'b0;
      lf_fuse     <= 1'b0;
    end else begin
      flash_start <= launch;
      lf_rd       <= lpm_hit;
      if (lpm_hit) lf_fuse <= z_addr[0];
      if (launch) begin
        flash_op    <= op;
        flash_addr  <= addr_n;
        flash_wdata <= data_n;
        busy        <= long_op;
        halt_cpu    <= long_op && in_nrww;
      end else if (busy && flash_done) begin
        busy     <= 1'b0;
        halt_cpu <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/selfprog_arm.sv
module selfprog_arm
  import selfprog_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int PAGE_LSB = 6,
  parameter int WIN      = 4,
  parameter int LPM_WIN  = 3,
  parameter logic [ADDR_W-1:0] NRWW_BASE = 16'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [4:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              store_stb,
  input  logic              load_stb,
  input  logic [ADDR_W-1:0] z_addr,
  input  logic [DATA_W-1:0] r_data,
  output logic              flash_start,
  output logic [2:0]        flash_op,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_wdata,
  input  logic              flash_done,
  output logic              flash_busy,
  output logic              halt_cpu,
  output logic              lf_rd,
  output logic              lf_fuse
);
  logic [4:0] cmd_q;
  sp_op_e     op_q;
  logic       dec_valid;
  sp_op_e     dec_op;
  logic       win_armed, win_last, win_early;
  logic       armed, launch, expire, wr_ok, lpm_hit, hold;

  selfprog_decode u_dec (
    .code  (csr_wdata),
    .valid (dec_valid),
    .op    (dec_op)
  );

  assign armed   = win_armed && !flash_busy;
  assign launch  = store_stb && armed;
  assign expire  = armed && win_last && !store_stb;
  assign wr_ok   = csr_we && dec_valid && !flash_busy && !launch && !expire;
  assign lpm_hit = load_stb && armed && win_early && (op_q == OP_LOCK);
  assign hold    = (op_q == OP_ERASE) || (op_q == OP_WRITE);

  selfprog_window #(.WIN(WIN), .LPM_WIN(LPM_WIN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_ok),
    .clear (launch || expire),
    .armed (win_armed),
    .last  (win_last),
    .early (win_early)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      op_q  <= OP_NONE;
    end else if (flash_busy && flash_done) begin
      cmd_q <= '0;
      op_q  <= OP_NONE;
    end else if ((launch && !hold) || expire) begin
      cmd_q <= '0;
      op_q  <= OP_NONE;
    end else if (wr_ok) begin
      cmd_q <= csr_wdata;
      op_q  <= dec_op;
    end
  end

  selfprog_launch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB), .NRWW_BASE(NRWW_BASE)
  ) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .op          (op_q),
    .lpm_hit     (lpm_hit),
    .z_addr      (z_addr),
    .r_data      (r_data),
    .flash_done  (flash_done),
    .flash_start (flash_start),
    .flash_op    (flash_op),
    .flash_addr  (flash_addr),
    .flash_wdata (flash_wdata),
    .busy        (flash_busy),
    .halt_cpu    (halt_cpu),
    .lf_rd       (lf_rd),
    .lf_fuse     (lf_fuse)
  );

  assign csr_rdata = {2'b00, flash_busy, cmd_q};
endmodule

// File: rtl/selfprog_arm_chk.sv
module selfprog_arm_chk #(
  parameter int WIN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       csr_we,
  input logic [7:0] csr_rdata,
  input logic       store_stb,
  input logic       flash_start,
  input logic       flash_done,
  input logic       flash_busy,
  input logic       halt_cpu
);
  localparam int AW = $clog2(WIN + 2) + 1;
  logic [AW-1:0] age;

  // counts cycles an idle armed code has been visible since the last write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (csr_we) age <= '0;
    else if (csr_rdata[4:0] != 5'd0 && !flash_busy) begin
      if (age != '1) age <= age + 1'b1;
    end else age <= '0;
  end

  p_window_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AW'(WIN));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[4:0] inside {5'b00000, 5'b00001, 5'b00011, 5'b00101, 5'b01001, 5'b10001});

  p_enable_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |-> (csr_rdata[0] && (csr_rdata[1] || csr_rdata[2])));

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_busy && flash_done) |=> (!flash_busy && csr_rdata[4:0] == 5'd0));

  p_halt_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cpu |-> flash_busy);

  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_start |=> !flash_start);

  p_busy_needs_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_busy) |-> $past(store_stb));
endmodule

bind selfprog_arm selfprog_arm_chk #(.WIN(WIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_we      (csr_we),
  .csr_rdata   (csr_rdata),
  .store_stb   (store_stb),
  .flash_start (flash_start),
  .flash_done  (flash_done),
  .flash_busy  (flash_busy),
  .halt_cpu    (halt_cpu)
);

// File: tb/selfprog_arm_bench.sv
module selfprog_arm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        store_stb = 1'b0, load_stb = 1'b0;
  logic [15:0] z_addr = '0, r_data = '0;
  logic        flash_start, flash_done = 1'b0, flash_busy, halt_cpu, lf_rd, lf_fuse;
  logic [2:0]  flash_op;
  logic [15:0] flash_addr, flash_wdata;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  selfprog_arm u_selfprog_arm (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .store_stb(store_stb), .load_stb(load_stb),
    .z_addr(z_addr), .r_data(r_data), .flash_start(flash_start),
    .flash_op(flash_op), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
    .flash_done(flash_done), .flash_busy(flash_busy), .halt_cpu(halt_cpu),
    .lf_rd(lf_rd), .lf_fuse(lf_fuse)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] code);
    csr_we = 1'b1; csr_wdata = code;
    step();
    csr_we = 1'b0;
  endtask

  // store strobe sampled on the d-th edge after the write edge
  task automatic store_at(input int d, input logic [15:0] z, input logic [15:0] r);
    repeat (d - 1) step();
    z_addr = z; r_data = r; store_stb = 1'b1;
    step();
    store_stb = 1'b0;
  endtask

  function automatic bit code_ok(input logic [4:0] c);
    return c == 5'b00001 || c == 5'b00011 || c == 5'b00101 || c == 5'b01001 || c == 5'b10001;
  endfunction

  function automatic logic [2:0] exp_op(input logic [4:0] c);
    case (c)
      5'b00001: return 3'd1;
      5'b00011: return 3'd2;
      5'b00101: return 3'd3;
      5'b01001: return 3'd4;
      5'b10001: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input logic [2:0] op, input logic [15:0] z);
    if (op == 3'd1) return {z[15:1], 1'b0};
    if (op == 3'd2 || op == 3'd3) return {z[15:6], 6'd0};
    return 16'd0;
  endfunction

  function automatic logic [15:0] exp_data(input logic [2:0] op, input logic [15:0] r);
    if (op == 3'd1) return r;
    if (op == 3'd4) return {8'd0, r[7:0]};
    return 16'd0;
  endfunction

  task automatic check_launch(input logic [4:0] c, input logic [15:0] z, input logic [15:0] r, input string tag);
    logic [2:0] op;
    op = exp_op(c);
    chk(flash_start == 1'b1, tag, 32'(flash_start), 32'd1);
    chk(flash_op == op, tag, 32'(flash_op), 32'(op));
    chk(flash_addr == exp_addr(op, z), tag, 32'(flash_addr), 32'(exp_addr(op, z)));
    chk(flash_wdata == exp_data(op, r), tag, 32'(flash_wdata), 32'(exp_data(op, r)));
  endtask

  task automatic finish_long(input int wait_cyc, input string tag);
    repeat (wait_cyc) step();
    flash_done = 1'b1;
    step();
    flash_done = 1'b0;
    chk(flash_busy == 1'b0 && csr_rdata[4:0] == 5'd0 && halt_cpu == 1'b0, tag,
        32'(csr_rdata), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    chk(csr_rdata == 8'd0 && flash_start == 0 && flash_busy == 0 && halt_cpu == 0 && lf_rd == 0,
        "reset R2", 32'(csr_rdata), 32'd0);
    rst_n = 1'b1;
    step();

    // R3 fill at first edge
    wr(5'b00001);
    chk(csr_rdata == 8'h01, "armed R2", 32'(csr_rdata), 32'h01);
    store_at(1, 16'h1235, 16'hBEEF);
    check_launch(5'b00001, 16'h1235, 16'hBEEF, "fill R3");
    chk(csr_rdata[4:0] == 0, "fill clears R3", 32'(csr_rdata), 32'd0);
    step();
    chk(flash_start == 0, "single pulse R10", 32'(flash_start), 32'd0);

    // R1 last edge of window honoured
    wr(5'b00001);
    store_at(4, 16'h0042, 16'h1234);
    check_launch(5'b00001, 16'h0042, 16'h1234, "edge4 R1");

    // R1 expiry
    wr(5'b00001);
    repeat (3) step();
    chk(csr_rdata[4:0] == 5'b00001, "still armed R1", 32'(csr_rdata), 32'h01);
    step();
    chk(csr_rdata[4:0] == 0, "expired R1", 32'(csr_rdata), 32'd0);
    store_at(1, 16'h0010, 16'h0001);
    chk(flash_start == 0, "late store R10", 32'(flash_start), 32'd0);

    // R2 illegal code
    wr(5'b00111);
    chk(csr_rdata[4:0] == 0, "illegal R2", 32'(csr_rdata), 32'd0);
    store_at(1, 16'h0010, 16'h0001);
    chk(flash_start == 0, "illegal no start R2", 32'(flash_start), 32'd0);

    // R4 erase below NRWW, writes while busy ignored
    wr(5'b00011);
    store_at(2, 16'h1277, 16'hFFFF);
    check_launch(5'b00011, 16'h1277, 16'hFFFF, "erase R4");
    chk(flash_busy && csr_rdata == 8'h23 && !halt_cpu, "erase busy R4", 32'(csr_rdata), 32'h23);
    wr(5'b00001);
    chk(csr_rdata == 8'h23, "busy write ignored R2", 32'(csr_rdata), 32'h23);
    store_at(1, 16'h0, 16'h0);
    chk(flash_start == 0, "store while busy R10", 32'(flash_start), 32'd0);
    finish_long(2, "erase done R4");

    // R5 write in NRWW
    wr(5'b00101);
    store_at(3, 16'hE0C5, 16'h5555);
    check_launch(5'b00101, 16'hE0C5, 16'h5555, "write R4");
    chk(halt_cpu == 1 && csr_rdata == 8'h25, "halt R5", 32'(halt_cpu), 32'd1);
    step();
    chk(halt_cpu == 1, "halt held R5", 32'(halt_cpu), 32'd1);
    finish_long(1, "halt released R5");

    // R6 lock set
    wr(5'b01001);
    store_at(1, 16'h3333, 16'hA55A);
    check_launch(5'b01001, 16'h3333, 16'hA55A, "lock R6");
    chk(csr_rdata[4:0] == 0, "lock clears R6", 32'(csr_rdata), 32'd0);

    // R7 load strobe on third edge
    wr(5'b01001);
    step(); step();
    z_addr = 16'h0001; load_stb = 1'b1;
    step();
    load_stb = 1'b0;
    chk(lf_rd == 1 && lf_fuse == 1, "lpm edge3 R7", {lf_rd, lf_fuse}, 32'd3);
    chk(csr_rdata[4:0] == 5'b01001, "lpm keeps cmd R7", 32'(csr_rdata), 32'h09);
    step();
    chk(lf_rd == 0, "lpm pulse R7", 32'(lf_rd), 32'd0);
    repeat (3) step();
    // R7 load strobe on fourth edge
    wr(5'b01001);
    repeat (3) step();
    z_addr = 16'h0000; load_stb = 1'b1;
    step();
    load_stb = 1'b0;
    chk(lf_rd == 0, "lpm edge4 R7", 32'(lf_rd), 32'd0);

    // R8 rww re-enable
    wr(5'b10001);
    store_at(2, 16'hFFFF, 16'hFFFF);
    check_launch(5'b10001, 16'hFFFF, 16'hFFFF, "rww R8");
    chk(csr_rdata[4:0] == 0, "rww clears R8", 32'(csr_rdata), 32'd0);

    // R9 write on expiry edge ignored
    wr(5'b00001);
    repeat (3) step();
    wr(5'b00011);
    chk(csr_rdata[4:0] == 0, "expiry beats write R9", 32'(csr_rdata), 32'd0);
    // R9 write on launch edge ignored
    wr(5'b00001);
    csr_we = 1'b1; csr_wdata = 5'b00011;
    store_at(1, 16'h0100, 16'h7777);
    csr_we = 1'b0;
    check_launch(5'b00001, 16'h0100, 16'h7777, "launch beats write R9");
    chk(csr_rdata[4:0] == 0, "launch write dropped R9", 32'(csr_rdata), 32'd0);
    // R9 reload restarts window
    wr(5'b00001);
    step(); step();
    wr(5'b01001);
    store_at(4, 16'h0200, 16'h00C3);
    check_launch(5'b01001, 16'h0200, 16'h00C3, "reload R9");

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [4:0] c;
      int d;
      logic [15:0] z, r;
      int k;
      k = $urandom_range(0, 6);
      case (k)
        0: c = 5'b00001;
        1: c = 5'b00011;
        2: c = 5'b00101;
        3: c = 5'b01001;
        4: c = 5'b10001;
        default: begin
          c = 5'($urandom);
          if (code_ok(c)) c = 5'b00000;
        end
      endcase
      d = $urandom_range(1, 6);
      z = 16'($urandom);
      r = 16'($urandom);
      wr(c);
      store_at(d, z, r);
      if (code_ok(c) && d <= 4) begin
        check_launch(c, z, r, "random R1");
        if (c == 5'b00011 || c == 5'b00101) begin
          chk(halt_cpu == (z >= 16'hE000), "random halt R5", 32'(halt_cpu), 32'(z >= 16'hE000));
          finish_long($urandom_range(0, 5), "random done R4");
        end
      end else begin
        chk(flash_start == 0 && csr_rdata[4:0] == 0, "random none R2", 32'(flash_start), 32'd0);
      end
      repeat (5) step();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule